// File: doc/BRIEF.md
# Register-Pair Double-Precision Instruction Decoder

This block takes one 32-bit instruction word per cycle from the double-precision floating-point class. In that class every 64-bit value sits in two 32-bit general registers. The block checks that the instruction is legal, including every register pair it names. It produces read and write register indices and an operation code for the floating-point unit. It holds the 32-entry, 32-bit general register file. For each operand it fetches the two halves from the file, and it writes the 64-bit result back as two registers.

The arithmetic itself is replaced by a stub datapath built from XOR combinations of the operands. With the stub, the bench can see exactly which registers were read and which were written. When an instruction is accepted, the result registers change and a one-cycle status-update strobe rises. When an instruction is rejected, only the illegal flag rises and the register file is left untouched. The bench preloads and inspects the register file through a separate host port.

Top module: `dpfp_pair_core`

## Requirements
- R1: An instruction is legal only when bits [31:26] are 6'b110010 and bits [7:0] are one of 0x10 add, 0x11 sub, 0x12 mul, 0x13 div, 0x14 itof, 0x15 ftoi, 0x16 rem, 0x17 madd, 0x34 stod, 0x35 dtos. Any other word raises illegal_o.
- R2: Fields: destination d in [25:21], a in [20:16], b in [15:11], offset bits dp in [10], ap in [9], bp in [8]. A 64-bit operand based at register r with offset p is {R[r], R[r+1+p]}, with the upper half taken from R[r].
- R3: If any pair the instruction uses has r+1+p greater than 31, the instruction is illegal.
- R4: When ext_en_i is low, every instruction is illegal.
- R5: itof and ftoi use pairs d and a. They are illegal unless b is zero and bit [8] is zero.
- R6: stod reads the single register R[a] and writes pair d. It requires b, bit [9] and bit [8] to be zero. dtos reads pair a and writes the single register d. It requires b, bit [10] and bit [8] to be zero.
- R7: madd reads pair d as an accumulator, in addition to pairs a and b, and writes its result back to pair d.
- R8: Stub results, where A, B and D are the 64-bit operands:
  - add, sub, mul, div and rem give A^B.
  - madd gives D^A^B.
  - itof and ftoi give A.
  - stod gives {R[a], 32'h0}.
  - dtos gives A[63:32]^A[31:0].
- R9: Register 0 always reads zero. Any write to index 0, from an instruction or from the host, is dropped.
- R10: A legal instruction presented with insn_valid_i at a clock edge updates the register file at that edge. In the following cycle only, fp_update_o and wr_en_o are high. An illegal one raises only illegal_o for one cycle and changes no register.
- R11: The host port writes a register at the clock edge. It reads any register combinationally. Instruction writes take priority over a host write to the same index.
- R12: While wr_en_o is high:
  - fp_op_o carries add 0, sub 1, mul 2, div 3, itof 4, ftoi 5, rem 6, madd 7, stod 8, dtos 9.
  - wr_hi_idx_o carries d.
  - wr_pair_o is 1 for all forms except dtos.
  - When wr_pair_o is 1, wr_lo_idx_o carries d+1+dp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid_i | input | 1 | Instruction present this cycle |
| insn_i | input | 32 | Instruction word |
| ext_en_i | input | 1 | Double-precision extension enabled |
| host_we_i | input | 1 | Host register write enable |
| host_waddr_i | input | 5 | Host write index |
| host_wdata_i | input | 32 | Host write data |
| host_raddr_i | input | 5 | Host read index |
| host_rdata_o | output | 32 | Host read data |
| illegal_o | output | 1 | Illegal-instruction strobe |
| fp_update_o | output | 1 | FP status update strobe |
| wr_en_o | output | 1 | Result written strobe |
| fp_op_o | output | 4 | Operation code to the FP unit |
| wr_hi_idx_o | output | 5 | Index written with the upper half |
| wr_lo_idx_o | output | 5 | Index written with the lower half |
| wr_pair_o | output | 1 | Lower half also written |

## Verification
The main sweep covers every operation with every destination index, all eight combinations of the three offset bits, and b both zero and non-zero. This separates pairs that fit from pairs that overflow at the top of the file. It also separates forms whose b field must be zero from forms that use it, and shows whether an offset bit was wrongly honoured or wrongly ignored. Because the register file keeps evolving under XOR results, a half read from the wrong register or written to the wrong register shows up in the full register dump after each instruction. Further words with a wrong major opcode, an unknown operation byte, or the extension disabled show that the rejection path leaves all 32 registers unchanged.

// File: rtl/dpfp_pkg.sv
package dpfp_pkg;
  localparam int XLEN    = 32;
  localparam int NREG    = 32;
  localparam int IDXW    = $clog2(NREG);
  localparam int OPW     = 4;
  localparam int NRDPORT = 7;

  localparam logic [5:0] MAJOR_DP = 6'b110010;

  localparam logic [7:0] SEL_ADD  = 8'h10;
  localparam logic [7:0] SEL_SUB  = 8'h11;
  localparam logic [7:0] SEL_MUL  = 8'h12;
  localparam logic [7:0] SEL_DIV  = 8'h13;
  localparam logic [7:0] SEL_ITOF = 8'h14;
  localparam logic [7:0] SEL_FTOI = 8'h15;
  localparam logic [7:0] SEL_REM  = 8'h16;
  localparam logic [7:0] SEL_MADD = 8'h17;
  localparam logic [7:0] SEL_STOD = 8'h34;
  localparam logic [7:0] SEL_DTOS = 8'h35;

  typedef logic [IDXW-1:0] idx_t;
  typedef logic [XLEN-1:0] word_t;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_MUL  = 4'd2,
    OP_DIV  = 4'd3,
    OP_ITOF = 4'd4,
    OP_FTOI = 4'd5,
    OP_REM  = 4'd6,
    OP_MADD = 4'd7,
    OP_STOD = 4'd8,
    OP_DTOS = 4'd9
  } fp_op_e;

  typedef struct packed {
    logic   legal;
    fp_op_e op;
    idx_t   a_hi;
    idx_t   a_lo;
    idx_t   b_hi;
    idx_t   b_lo;
    idx_t   d_hi;
    idx_t   d_lo;
    logic   wr_lo_en;
  } dec_t;
endpackage

// File: rtl/dpfp_pair_decode.sv
module dpfp_pair_decode
  import dpfp_pkg::*;
(
  input  logic [31:0] insn_i,
  input  logic        ext_en_i,
  output dec_t        dec_o
);
  // Pair fits when r + 1 + p stays below the register count.
  function automatic logic pair_fits(input idx_t r, input logic p);
    logic [IDXW:0] sum;
    sum = {1'b0, r} + (IDXW+1)'(1) + {{IDXW{1'b0}}, p};
    return ~sum[IDXW];
  endfunction

  function automatic idx_t pair_low(input idx_t r, input logic p);
    return r + idx_t'(1) + {{(IDXW-1){1'b0}}, p};
  endfunction

  typedef enum logic [1:0] {CLS_THREE, CLS_CONV, CLS_WIDEN, CLS_NARROW} cls_e;

  idx_t       fd, fa, fb;
  logic       pd, pa, pb;
  logic [7:0] sel;
  logic       major_ok;
  logic       known;
  cls_e       cls;
  fp_op_e     op;
  logic       fields_ok;
  logic       pairs_ok;

  assign fd       = insn_i[25:21];
  assign fa       = insn_i[20:16];
  assign fb       = insn_i[15:11];
  assign pd       = insn_i[10];
  assign pa       = insn_i[9];
  assign pb       = insn_i[8];
  assign sel      = insn_i[7:0];
  assign major_ok = (insn_i[31:26] == MAJOR_DP);

  always_comb begin
    known = 1'b1;
    cls   = CLS_THREE;
    op    = OP_ADD;
    unique case (sel)
      SEL_ADD:  op = OP_ADD;
      SEL_SUB:  op = OP_SUB;
      SEL_MUL:  op = OP_MUL;
      SEL_DIV:  op = OP_DIV;
      SEL_REM:  op = OP_REM;
      SEL_MADD: op = OP_MADD;
      SEL_ITOF: begin op = OP_ITOF; cls = CLS_CONV;   end
      SEL_FTOI: begin op = OP_FTOI; cls = CLS_CONV;   end
      SEL_STOD: begin op = OP_STOD; cls = CLS_WIDEN;  end
      SEL_DTOS: begin op = OP_DTOS; cls = CLS_NARROW; end
      default:  known = 1'b0;
    endcase
  end

  always_comb begin
    fields_ok = 1'b1;
    pairs_ok  = 1'b1;
    unique case (cls)
      CLS_THREE: begin
        pairs_ok = pair_fits(fd, pd) & pair_fits(fa, pa) & pair_fits(fb, pb);
      end
      CLS_CONV: begin
        fields_ok = (fb == '0) & ~pb;
        pairs_ok  = pair_fits(fd, pd) & pair_fits(fa, pa);
      end
      CLS_WIDEN: begin
        fields_ok = (fb == '0) & ~pa & ~pb;
        pairs_ok  = pair_fits(fd, pd);
      end
      CLS_NARROW: begin
        fields_ok = (fb == '0) & ~pd & ~pb;
        pairs_ok  = pair_fits(fa, pa);
      end
      default: begin
        fields_ok = 1'b0;
        pairs_ok  = 1'b0;
      end
    endcase
  end

  always_comb begin
    dec_o.legal    = ext_en_i & major_ok & known & fields_ok & pairs_ok;
    dec_o.op       = op;
    dec_o.a_hi     = fa;
    dec_o.a_lo     = pair_low(fa, pa);
    dec_o.b_hi     = fb;
    dec_o.b_lo     = pair_low(fb, pb);
    dec_o.d_hi     = fd;
    dec_o.d_lo     = pair_low(fd, pd);
    dec_o.wr_lo_en = (cls != CLS_NARROW);
  end
endmodule

// File: rtl/dpfp_pair_rf.sv
module dpfp_pair_rf #(
  parameter  int DATA_W = 32,
  parameter  int NREG   = 32,
  parameter  int NRD    = 7,
  localparam int IDXW   = $clog2(NREG)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we_hi_i,
  input  logic [IDXW-1:0]             wa_hi_i,
  input  logic [DATA_W-1:0]           wd_hi_i,
  input  logic                        we_lo_i,
  input  logic [IDXW-1:0]             wa_lo_i,
  input  logic [DATA_W-1:0]           wd_lo_i,
  input  logic                        hwe_i,
  input  logic [IDXW-1:0]             hwa_i,
  input  logic [DATA_W-1:0]           hwd_i,
  input  logic [NRD-1:0][IDXW-1:0]    raddr_i,
  output logic [NRD-1:0][DATA_W-1:0]  rdata_o
);
  logic [NREG-1:0][DATA_W-1:0] mem;

  assign mem[0] = '0;

  for (genvar g = 1; g < NREG; g++) begin : g_reg
    logic [DATA_W-1:0] q;
    logic [DATA_W-1:0] nxt;
    logic              en;

    always_comb begin
      en  = 1'b0;
      nxt = q;
      if (we_hi_i && wa_hi_i == IDXW'(g)) begin
        en  = 1'b1;
        nxt = wd_hi_i;
      end else if (we_lo_i && wa_lo_i == IDXW'(g)) begin
        en  = 1'b1;
        nxt = wd_lo_i;
      end else if (hwe_i && hwa_i == IDXW'(g)) begin
        en  = 1'b1;
        nxt = hwd_i;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (en) begin
        q <= nxt;
      end
    end

    assign mem[g] = q;
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rdata_o[r] = mem[raddr_i[r]];
  end
endmodule

// File: rtl/dpfp_pair_stub.sv
module dpfp_pair_stub
  import dpfp_pkg::*;
(
  input  fp_op_e            op_i,
  input  logic [2*XLEN-1:0] opa_i,
  input  logic [2*XLEN-1:0] opb_i,
  input  logic [2*XLEN-1:0] opd_i,
  output word_t             res_hi_o,
  output word_t             res_lo_o
);
  logic [2*XLEN-1:0] wide;

  always_comb begin
    wide = '0;
    unique case (op_i)
      OP_ADD, OP_SUB, OP_MUL, OP_DIV, OP_REM: wide = opa_i ^ opb_i;
      OP_MADD:           wide = opd_i ^ opa_i ^ opb_i;
      OP_ITOF, OP_FTOI:  wide = opa_i;
      OP_STOD:           wide = {opa_i[2*XLEN-1:XLEN], {XLEN{1'b0}}};
      OP_DTOS:           wide = {opa_i[2*XLEN-1:XLEN] ^ opa_i[XLEN-1:0], {XLEN{1'b0}}};
      default:           wide = '0;
    endcase
  end

  assign res_hi_o = wide[2*XLEN-1:XLEN];
  assign res_lo_o = wide[XLEN-1:0];
endmodule

// File: rtl/dpfp_pair_core.sv
module dpfp_pair_core
  import dpfp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        insn_valid_i,
  input  logic [31:0] insn_i,
  input  logic        ext_en_i,
  input  logic        host_we_i,
  input  logic [4:0]  host_waddr_i,
  input  logic [31:0] host_wdata_i,
  input  logic [4:0]  host_raddr_i,
  output logic [31:0] host_rdata_o,
  output logic        illegal_o,
  output logic        fp_update_o,
  output logic        wr_en_o,
  output logic [3:0]  fp_op_o,
  output logic [4:0]  wr_hi_idx_o,
  output logic [4:0]  wr_lo_idx_o,
  output logic        wr_pair_o
);
  localparam int RP_AHI  = 0;
  localparam int RP_ALO  = 1;
  localparam int RP_BHI  = 2;
  localparam int RP_BLO  = 3;
  localparam int RP_DHI  = 4;
  localparam int RP_DLO  = 5;
  localparam int RP_HOST = 6;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  dec_t                           dec;
  logic [NRDPORT-1:0][IDXW-1:0]   raddr;
  logic [NRDPORT-1:0][XLEN-1:0]   rdata;
  word_t                          res_hi;
  word_t                          res_lo;
  logic                           accept;
  logic                           we_hi;
  logic                           we_lo;

  dpfp_pair_decode u_dec (
    .insn_i   (insn_i),
    .ext_en_i (ext_en_i),
    .dec_o    (dec)
  );

  always_comb begin
    raddr[RP_AHI]  = dec.a_hi;
    raddr[RP_ALO]  = dec.a_lo;
    raddr[RP_BHI]  = dec.b_hi;
    raddr[RP_BLO]  = dec.b_lo;
    raddr[RP_DHI]  = dec.d_hi;
    raddr[RP_DLO]  = dec.d_lo;
    raddr[RP_HOST] = host_raddr_i;
  end

  dpfp_pair_stub u_stub (
    .op_i     (dec.op),
    .opa_i    ({rdata[RP_AHI], rdata[RP_ALO]}),
    .opb_i    ({rdata[RP_BHI], rdata[RP_BLO]}),
    .opd_i    ({rdata[RP_DHI], rdata[RP_DLO]}),
    .res_hi_o (res_hi),
    .res_lo_o (res_lo)
  );

  assign accept = insn_valid_i & dec.legal;
  assign we_hi  = accept;
  assign we_lo  = accept & dec.wr_lo_en;

  dpfp_pair_rf #(
    .DATA_W (XLEN),
    .NREG   (NREG),
    .NRD    (NRDPORT)
  ) u_rf (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .we_hi_i (we_hi),
    .wa_hi_i (dec.d_hi),
    .wd_hi_i (res_hi),
    .we_lo_i (we_lo),
    .wa_lo_i (dec.d_lo),
    .wd_lo_i (res_lo),
    .hwe_i   (host_we_i),
    .hwa_i   (host_waddr_i),
    .hwd_i   (host_wdata_i),
    .raddr_i (raddr),
    .rdata_o (rdata)
  );

  assign host_rdata_o = rdata[RP_HOST];

  // strobe and write-report registers
  logic   ill_q, ill_d;
  logic   upd_q, upd_d;
  fp_op_e op_q;
  idx_t   whi_q, wlo_q;
  logic   wpair_q;
  logic   info_en;

  always_comb begin
    ill_d   = insn_valid_i & ~dec.legal;
    upd_d   = accept;
    info_en = accept;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ill_q <= 1'b0;
      upd_q <= 1'b0;
    end else begin
      ill_q <= ill_d;
      upd_q <= upd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      op_q    <= OP_ADD;
      whi_q   <= '0;
      wlo_q   <= '0;
      wpair_q <= 1'b0;
    end else if (info_en) begin
      op_q    <= dec.op;
      whi_q   <= dec.d_hi;
      wlo_q   <= dec.d_lo;
      wpair_q <= dec.wr_lo_en;
    end
  end

  assign illegal_o   = ill_q;
  assign fp_update_o = upd_q;
  assign wr_en_o     = upd_q;
  assign fp_op_o     = op_q;
  assign wr_hi_idx_o = whi_q;
  assign wr_lo_idx_o = wlo_q;
  assign wr_pair_o   = wpair_q;
endmodule

// File: rtl/dpfp_pair_chk.sv
module dpfp_pair_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        insn_valid_i,
  input logic [31:0] insn_i,
  input logic        ext_en_i,
  input logic        host_we_i,
  input logic [4:0]  host_waddr_i,
  input logic [31:0] host_wdata_i,
  input logic [4:0]  host_raddr_i,
  input logic [31:0] host_rdata_o,
  input logic        illegal_o,
  input logic        fp_update_o,
  input logic        wr_en_o,
  input logic [3:0]  fp_op_o,
  input logic [4:0]  wr_hi_idx_o,
  input logic [4:0]  wr_lo_idx_o,
  input logic        wr_pair_o
);
  // R10
  illegal_excl_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(illegal_o && fp_update_o));

  // R10
  update_with_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fp_update_o |-> wr_en_o);

  // R10
  strobe_needs_insn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fp_update_o || illegal_o) |-> $past(insn_valid_i));

  // R4
  ext_off_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid_i && !ext_en_i) |=> illegal_o);

  // R1
  bad_major_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid_i && insn_i[31:26] != 6'b110010) |=> illegal_o);

  // R3
  top_pair_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid_i && insn_i[7:0] == 8'h10 && insn_i[25:21] == 5'd31) |=> illegal_o);

  // R9
  zero_reg_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_raddr_i == 5'd0) |-> (host_rdata_o == 32'd0));
endmodule

bind dpfp_pair_core dpfp_pair_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .insn_valid_i (insn_valid_i),
  .insn_i       (insn_i),
  .ext_en_i     (ext_en_i),
  .host_we_i    (host_we_i),
  .host_waddr_i (host_waddr_i),
  .host_wdata_i (host_wdata_i),
  .host_raddr_i (host_raddr_i),
  .host_rdata_o (host_rdata_o),
  .illegal_o    (illegal_o),
  .fp_update_o  (fp_update_o),
  .wr_en_o      (wr_en_o),
  .fp_op_o      (fp_op_o),
  .wr_hi_idx_o  (wr_hi_idx_o),
  .wr_lo_idx_o  (wr_lo_idx_o),
  .wr_pair_o    (wr_pair_o)
);

// File: tb/sim_dpfp_pair_core.sv
`timescale 1ns/1ps
module sim_dpfp_pair_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        insn_valid_i = 1'b0;
  logic [31:0] insn_i = '0;
  logic        ext_en_i = 1'b1;
  logic        host_we_i = 1'b0;
  logic [4:0]  host_waddr_i = '0;
  logic [31:0] host_wdata_i = '0;
  logic [4:0]  host_raddr_i = '0;
  logic [31:0] host_rdata_o;
  logic        illegal_o, fp_update_o, wr_en_o, wr_pair_o;
  logic [3:0]  fp_op_o;
  logic [4:0]  wr_hi_idx_o, wr_lo_idx_o;

  always #4 clk = ~clk;

  dpfp_pair_core u0 (.*);

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] mdl [32];

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input int i);
    return (i == 0) ? 32'd0 : mdl[i];
  endfunction

  function automatic logic [31:0] mk(input logic [7:0] sel, input int d, input int a, input int b,
                                     input bit dp, input bit ap, input bit bp);
    return {6'b110010, d[4:0], a[4:0], b[4:0], dp, ap, bp, sel};
  endfunction

  task automatic host_wr(input int idx, input logic [31:0] val);
    @(negedge clk);
    host_we_i = 1'b1; host_waddr_i = idx[4:0]; host_wdata_i = val;
    @(negedge clk);
    host_we_i = 1'b0;
    if (idx != 0) mdl[idx] = val;
  endtask

  // compare all registers against the model (R9, R11 read path)
  task automatic dump_check(input string tag);
    bit ok = 1'b1;
    logic [31:0] bad_a = '0, bad_e = '0;
    for (int i = 0; i < 32; i++) begin
      host_raddr_i = i[4:0];
      #1;
      if (host_rdata_o !== rd(i)) begin
        if (ok) begin bad_a = host_rdata_o; bad_e = rd(i); end
        ok = 1'b0;
      end
    end
    check(ok, tag, {32'd0, bad_a}, {32'd0, bad_e});
  endtask

  task automatic run(input logic [31:0] w, input bit ext);
    int d = w[25:21], a = w[20:16], b = w[15:11];
    int dp = w[10], ap = w[9], bp = w[8];
    bit known = 1'b1;
    int cls = 0;
    int opc = 0;
    bit legal;
    logic [63:0] va, vb, vd, res;
    case (w[7:0])
      8'h10: opc = 0;  8'h11: opc = 1;  8'h12: opc = 2;  8'h13: opc = 3;
      8'h16: opc = 6;  8'h17: opc = 7;
      8'h14: begin opc = 4; cls = 1; end
      8'h15: begin opc = 5; cls = 1; end
      8'h34: begin opc = 8; cls = 2; end
      8'h35: begin opc = 9; cls = 3; end
      default: known = 1'b0;
    endcase
    legal = ext && (w[31:26] == 6'b110010) && known;                 // R1 R4
    case (cls)
      0: legal = legal && (d+1+dp < 32) && (a+1+ap < 32) && (b+1+bp < 32); // R3
      1: legal = legal && b == 0 && bp == 0 && (d+1+dp < 32) && (a+1+ap < 32); // R5
      2: legal = legal && b == 0 && ap == 0 && bp == 0 && (d+1+dp < 32); // R6
      default: legal = legal && b == 0 && dp == 0 && bp == 0 && (a+1+ap < 32); // R6
    endcase
    @(negedge clk);
    insn_valid_i = 1'b1; insn_i = w; ext_en_i = ext;
    @(posedge clk);
    #2;
    check(illegal_o === !legal, "R10 illegal strobe", {63'd0, illegal_o}, {63'd0, !legal});
    check(fp_update_o === legal && wr_en_o === legal, "R10 update/write strobe",
          {62'd0, fp_update_o, wr_en_o}, {62'd0, legal, legal});
    if (legal) begin
      check(fp_op_o == opc[3:0], "R12 op code", {60'd0, fp_op_o}, opc);
      check(wr_hi_idx_o == d[4:0] && wr_pair_o == (cls != 3), "R12 write index/pair",
            {58'd0, wr_pair_o, wr_hi_idx_o}, {58'd0, cls != 3, d[4:0]});
      if (cls != 3)
        check(wr_lo_idx_o == 5'(d+1+dp), "R2 low index", {59'd0, wr_lo_idx_o}, d+1+dp);
      // R2 operand halves, R7 accumulator, R8 stub
      va = {rd(a), (a+1+ap < 32) ? rd(a+1+ap) : 32'd0};
      vb = {rd(b), (b+1+bp < 32) ? rd(b+1+bp) : 32'd0};
      vd = {rd(d), (d+1+dp < 32) ? rd(d+1+dp) : 32'd0};
      case (opc)
        7:       res = vd ^ va ^ vb;
        4, 5:    res = va;
        8:       res = {rd(a), 32'd0};
        9:       res = {va[63:32] ^ va[31:0], 32'd0};
        default: res = va ^ vb;
      endcase
      if (cls == 3) begin
        if (d != 0) mdl[d] = res[63:32];
      end else begin
        if (d != 0) mdl[d] = res[63:32];
        mdl[d+1+dp] = res[31:0];
      end
    end
    @(negedge clk);
    insn_valid_i = 1'b0;
    @(posedge clk);
    #2;
    check(!illegal_o && !fp_update_o, "R10 one-cycle strobe", {62'd0, illegal_o, fp_update_o}, 64'd0);
    dump_check(legal ? "R8 R7 R6 register results" : "R10 illegal writes nothing");
  endtask

  initial begin
    #(8 * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] sels [10] = '{8'h10, 8'h11, 8'h12, 8'h13, 8'h14, 8'h15, 8'h16, 8'h17, 8'h34, 8'h35};
    for (int i = 0; i < 32; i++) mdl[i] = 32'd0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #2;
    check(!illegal_o && !fp_update_o && !wr_en_o, "R10 reset strobes low",
          {61'd0, illegal_o, fp_update_o, wr_en_o}, 64'd0);
    dump_check("R11 reset register file zero");
    // R11 preload, R9 host write to index 0 dropped
    for (int i = 0; i < 32; i++) host_wr(i, 32'h9E3779B9 * (i + 1) ^ 32'h5A5A0000);
    dump_check("R9 R11 preload");
    // R1 wrong major, unknown selector; R4 extension off
    run({6'b110011, 26'h0042010}, 1'b1);
    run(mk(8'h18, 2, 4, 6, 0, 0, 0), 1'b1);
    run(mk(8'h00, 2, 4, 6, 0, 0, 0), 1'b1);
    run(mk(8'h10, 2, 4, 6, 0, 0, 0), 1'b0);
    run(mk(8'h34, 2, 4, 0, 0, 0, 0), 1'b0);
    // R3 R5 R6 R7 R8 sweep
    for (int s = 0; s < 10; s++)
      for (int d = 0; d < 32; d++)
        for (int m = 0; m < 8; m++)
          for (int z = 0; z < 2; z++)
            run(mk(sels[s], d, (d * 7 + 3) % 32, z ? (d * 13 + 5) % 32 : 0, m[2], m[1], m[0]), 1'b1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule